// File: doc/BRIEF.md
# Interrupt Acceptance and Dispatch Controller

This controller sits between a group of prioritized peripheral interrupt sources and the sequencer of a CPU. At every instruction boundary it decides whether a hardware request may be taken. A source is eligible when three flags are all set: the CPU's global interrupt enable, the source's request flag and the source's enable flag. Its programmed level must also be numerically below the CPU's current level mask, so a smaller level means a higher priority. A repeating string instruction raises the boundary strobe after each repetition, so a request can be taken between repetitions.

A taken request follows one of three service paths. The first path starts a DMA service, which runs until the peripheral reports that the count is used up or that the transfer should end. It then continues into vectored entry. The second path starts a descriptor-driven I/O service, which pushes no context. The third path saves six CPU registers on the system stack through a write handshake. It then raises a one-cycle vector strobe, loads the level mask with the request's level and selects the system stack. A software INT request is served whatever the enable and mask state are. Hardware acceptance is blocked while any service is in progress.

Top module: `irq_dispatch`

## Requirements
- R1: A hardware source is taken only when `cpu_ie`, its `src_req` bit and its `src_en` bit are all 1.
- R2: A hardware source is taken only when its level (field `src_lvl[i*LVL_W +: LVL_W]`) is strictly less than `cpu_ilm`. An equal level is not taken.
- R3: Among eligible sources, the one with the smallest level wins, and a tie goes to the lowest index. In the accept cycle, `acc_pulse` is high for one cycle, `acc_src` gives the winner and `acc_swi` is 0. For a software request, `acc_swi` is 1 and `acc_src` is 0.
- R4: Acceptance happens only in a cycle where `at_boundary` is 1 and `busy` is 0. A pending request gives no acceptance while `at_boundary` is low or while a service is running.
- R5: When the winner's `src_dma_en` bit is 1, `dma_start` pulses in the accept cycle, even if the descriptor flag is also set. No stack write occurs until `dma_done`. The cycle that holds `dma_done` starts the vectored entry.
- R6: When `src_dma_en` is 0 and `src_desc_en` is 1, `desc_start` pulses in the accept cycle. No stack write, vector strobe or mask load follows, and `busy` falls after `desc_done`.
- R7: Vectored entry makes six stack writes, one for each `stk_wr_valid`/`stk_wr_ready` handshake. The data order is A, DPR, DTB, PCB, PC, PS. The addresses are `sp_in-1` down to `sp_in-6` (the pointer is decremented before each write). Address and data hold while `stk_wr_ready` is low.
- R8: The cycle after the last stack write, `vec_valid` and `s_flag_set` are high for exactly one cycle, and `vec_addr` = `VEC_BASE - 4*number`. A hardware source uses its index as the number. For a hardware source, `ilm_load` is high in the same cycle and `ilm_value` is the source's level.
- R9: A software request (`swi_req` at a boundary) is taken regardless of `cpu_ie` and `cpu_ilm`, but only when no hardware source is taken in that cycle. It uses `swi_num` as the vector number and does not assert `ilm_load`.
- R10: After reset, `acc_pulse`, `busy`, `dma_start`, `desc_start`, `stk_wr_valid`, `vec_valid` and `ilm_load` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_ilm | input | LVL_W | CPU current level mask |
| at_boundary | input | 1 | Instruction or repetition boundary strobe |
| src_req | input | NSRC | Per-source request flags |
| src_en | input | NSRC | Per-source enable flags |
| src_lvl | input | NSRC*LVL_W | Per-source programmed levels |
| src_dma_en | input | NSRC | Per-source DMA service enable |
| src_desc_en | input | NSRC | Per-source descriptor service enable |
| swi_req | input | 1 | Software INT request |
| swi_num | input | VEC_W | Software INT vector number |
| ctx_a | input | DATA_W | Accumulator value to save |
| ctx_dpr | input | DATA_W | Direct page register value |
| ctx_dtb | input | DATA_W | Data bank register value |
| ctx_pcb | input | DATA_W | Program bank register value |
| ctx_pc | input | DATA_W | Program counter value |
| ctx_ps | input | DATA_W | Processor status value |
| sp_in | input | ADDR_W | System stack pointer before entry |
| dma_done | input | 1 | DMA count exhausted or end request |
| desc_done | input | 1 | Descriptor service finished |
| stk_wr_ready | input | 1 | Stack write accepted |
| acc_pulse | output | 1 | Request accepted this cycle |
| acc_swi | output | 1 | Accepted request is software |
| acc_src | output | $clog2(NSRC) | Accepted hardware source index |
| busy | output | 1 | A service is in progress |
| dma_start | output | 1 | Start DMA service for `acc_src` |
| desc_start | output | 1 | Start descriptor service for `acc_src` |
| stk_wr_valid | output | 1 | Stack write request |
| stk_wr_addr | output | ADDR_W | Stack write address |
| stk_wr_data | output | DATA_W | Stack write data |
| ilm_load | output | 1 | Load level mask |
| ilm_value | output | LVL_W | New level mask value |
| s_flag_set | output | 1 | Select system stack |
| vec_valid | output | 1 | Vector address strobe |
| vec_addr | output | ADDR_W | Vector address |

## Verification
The assertions check four properties on every cycle. A hardware acceptance must satisfy the flag and strict level conditions, and it must fall on a boundary while idle. A stalled stack write must hold its address and data, and each completed write must step the address down by one. The vector strobe must last a single cycle. Only the bench scenarios can show the remaining behaviour: which source wins a tie or a level contest, the exact register order, the routing between the DMA, descriptor and vectored paths, the DMA path continuing into vectored entry, software requests ignoring the mask, and requests being ignored off-boundary or while busy.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    parameter int DATA_W = 16;
    parameter int ADDR_W = 24;
    parameter int N_CTX  = 6;
    localparam int CNT_W = $clog2(N_CTX);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] dpr;
        logic [DATA_W-1:0] dtb;
        logic [DATA_W-1:0] pcb;
        logic [DATA_W-1:0] pc;
        logic [DATA_W-1:0] ps;
    } ctx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DMA,
        ST_DESC,
        ST_PUSH,
        ST_VEC
    } dstate_t;

    // Word pushed at step i of the context save, first step first.
    function automatic logic [DATA_W-1:0] ctx_word(input ctx_t c, input logic [CNT_W-1:0] i);
        case (i)
            CNT_W'(0): ctx_word = c.acc;
            CNT_W'(1): ctx_word = c.dpr;
            CNT_W'(2): ctx_word = c.dtb;
            CNT_W'(3): ctx_word = c.pcb;
            CNT_W'(4): ctx_word = c.pc;
            default:   ctx_word = c.ps;
        endcase
    endfunction

endpackage

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
    parameter int NSRC  = 4,
    parameter int LVL_W = 3,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic                  cpu_ie,
    input  logic [LVL_W-1:0]      cpu_ilm,
    input  logic [NSRC-1:0]       src_req,
    input  logic [NSRC-1:0]       src_en,
    input  logic [NSRC*LVL_W-1:0] src_lvl,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic [LVL_W-1:0]      win_lvl
);

    logic [NSRC-1:0] elig;

    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign elig[g] = cpu_ie & src_req[g] & src_en[g] &
                         (src_lvl[g*LVL_W +: LVL_W] < cpu_ilm);
    end

    always_comb begin
        logic             found;
        logic [IDX_W-1:0] bidx;
        logic [LVL_W-1:0] blvl;
        found = 1'b0;
        bidx  = '0;
        blvl  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || src_lvl[i*LVL_W +: LVL_W] < blvl)) begin
                found = 1'b1;
                bidx  = IDX_W'(i);
                blvl  = src_lvl[i*LVL_W +: LVL_W];
            end
        end
        win_valid = found;
        win_idx   = bidx;
        win_lvl   = blvl;
    end

endmodule

// File: rtl/irqd_pusher.sv
module irqd_pusher
    import irqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ctx_t              ctx_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    logic              active;
    logic [CNT_W-1:0]  step;
    ctx_t              ctx_q;
    logic [ADDR_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            step   <= '0;
            ctx_q  <= '0;
            sp_q   <= '0;
        end else if (start) begin
            active <= 1'b1;
            step   <= '0;
            ctx_q  <= ctx_in;
            sp_q   <= sp_in - ADDR_W'(1);
        end else if (active && wr_ready) begin
            sp_q <= sp_q - ADDR_W'(1);
            step <= step + CNT_W'(1);
            if (step == CNT_W'(N_CTX-1)) begin
                active <= 1'b0;
            end
        end
    end

    assign wr_valid = active;
    assign wr_addr  = sp_q;
    assign wr_data  = ctx_word(ctx_q, step);
    assign done     = active && wr_ready && (step == CNT_W'(N_CTX-1));

    // R7: a stalled write keeps its address and data
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R7: each completed write except the last moves one word down
    a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready && !done |=> wr_valid && (wr_addr == $past(wr_addr) - ADDR_W'(1)));

endmodule

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
    import irqd_pkg::*;
#(
    parameter int                NSRC     = 4,
    parameter int                LVL_W    = 3,
    parameter int                VEC_W    = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'h00FFFC,
    parameter int                IDX_W    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              at_boundary,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [LVL_W-1:0]  win_lvl,
    input  logic              win_dma,
    input  logic              win_desc,
    input  logic              swi_req,
    input  logic [VEC_W-1:0]  swi_num,
    input  logic              dma_done,
    input  logic              desc_done,
    input  logic              push_done,
    output logic              acc_pulse,
    output logic              acc_swi,
    output logic [IDX_W-1:0]  acc_src,
    output logic              busy,
    output logic              dma_start,
    output logic              desc_start,
    output logic              push_start,
    output logic              ilm_load,
    output logic [LVL_W-1:0]  ilm_value,
    output logic              s_flag_set,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr
);

    dstate_t          st, nxt;
    logic             swi_q;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] num_q;
    logic             take_hw, take_sw;

    always_comb begin
        nxt        = st;
        take_hw    = 1'b0;
        take_sw    = 1'b0;
        dma_start  = 1'b0;
        desc_start = 1'b0;
        push_start = 1'b0;
        case (st)
            ST_IDLE: begin
                if (at_boundary && win_valid) begin
                    take_hw = 1'b1;
                    if (win_dma) begin
                        dma_start = 1'b1;
                        nxt       = ST_DMA;
                    end else if (win_desc) begin
                        desc_start = 1'b1;
                        nxt        = ST_DESC;
                    end else begin
                        push_start = 1'b1;
                        nxt        = ST_PUSH;
                    end
                end else if (at_boundary && swi_req) begin
                    take_sw    = 1'b1;
                    push_start = 1'b1;
                    nxt        = ST_PUSH;
                end
            end
            ST_DMA: begin
                if (dma_done) begin
                    push_start = 1'b1;
                    nxt        = ST_PUSH;
                end
            end
            ST_DESC: begin
                if (desc_done) nxt = ST_IDLE;
            end
            ST_PUSH: begin
                if (push_done) nxt = ST_VEC;
            end
            ST_VEC:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            swi_q <= 1'b0;
            lvl_q <= '0;
            num_q <= '0;
        end else begin
            st <= nxt;
            if (take_hw) begin
                swi_q <= 1'b0;
                lvl_q <= win_lvl;
                num_q <= VEC_W'(win_idx);
            end else if (take_sw) begin
                swi_q <= 1'b1;
                lvl_q <= '0;
                num_q <= swi_num;
            end
        end
    end

    assign acc_pulse  = take_hw | take_sw;
    assign acc_swi    = take_sw;
    assign acc_src    = take_hw ? win_idx : '0;
    assign busy       = (st != ST_IDLE);
    assign vec_valid  = (st == ST_VEC);
    assign s_flag_set = (st == ST_VEC);
    assign ilm_load   = (st == ST_VEC) && !swi_q;
    assign ilm_value  = lvl_q;
    assign vec_addr   = VEC_BASE - (ADDR_W'(num_q) << 2);

    // R8: the vector strobe lasts a single cycle
    a_r8_vec_single: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R5: while waiting for the DMA service no vectored entry begins
    a_r5_dma_wait: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DMA) && !dma_done |=> !vec_valid && (st != ST_PUSH));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irqd_pkg::*;
#(
    parameter int                NSRC     = 4,
    parameter int                LVL_W    = 3,
    parameter int                VEC_W    = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'h00FFFC
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_ie,
    input  logic [LVL_W-1:0]         cpu_ilm,
    input  logic                     at_boundary,
    input  logic [NSRC-1:0]          src_req,
    input  logic [NSRC-1:0]          src_en,
    input  logic [NSRC*LVL_W-1:0]    src_lvl,
    input  logic [NSRC-1:0]          src_dma_en,
    input  logic [NSRC-1:0]          src_desc_en,
    input  logic                     swi_req,
    input  logic [VEC_W-1:0]         swi_num,
    input  logic [DATA_W-1:0]        ctx_a,
    input  logic [DATA_W-1:0]        ctx_dpr,
    input  logic [DATA_W-1:0]        ctx_dtb,
    input  logic [DATA_W-1:0]        ctx_pcb,
    input  logic [DATA_W-1:0]        ctx_pc,
    input  logic [DATA_W-1:0]        ctx_ps,
    input  logic [ADDR_W-1:0]        sp_in,
    input  logic                     dma_done,
    input  logic                     desc_done,
    input  logic                     stk_wr_ready,
    output logic                     acc_pulse,
    output logic                     acc_swi,
    output logic [$clog2(NSRC)-1:0]  acc_src,
    output logic                     busy,
    output logic                     dma_start,
    output logic                     desc_start,
    output logic                     stk_wr_valid,
    output logic [ADDR_W-1:0]        stk_wr_addr,
    output logic [DATA_W-1:0]        stk_wr_data,
    output logic                     ilm_load,
    output logic [LVL_W-1:0]         ilm_value,
    output logic                     s_flag_set,
    output logic                     vec_valid,
    output logic [ADDR_W-1:0]        vec_addr
);

    localparam int IDX_W = $clog2(NSRC);

    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [LVL_W-1:0] win_lvl;
    logic             push_start, push_done;
    ctx_t             ctx_now;

    assign ctx_now = '{acc: ctx_a, dpr: ctx_dpr, dtb: ctx_dtb,
                       pcb: ctx_pcb, pc: ctx_pc, ps: ctx_ps};

    irqd_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .cpu_ie    (cpu_ie),
        .cpu_ilm   (cpu_ilm),
        .src_req   (src_req),
        .src_en    (src_en),
        .src_lvl   (src_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    irqd_ctrl #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
                .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .at_boundary (at_boundary),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .win_lvl     (win_lvl),
        .win_dma     (src_dma_en[win_idx]),
        .win_desc    (src_desc_en[win_idx]),
        .swi_req     (swi_req),
        .swi_num     (swi_num),
        .dma_done    (dma_done),
        .desc_done   (desc_done),
        .push_done   (push_done),
        .acc_pulse   (acc_pulse),
        .acc_swi     (acc_swi),
        .acc_src     (acc_src),
        .busy        (busy),
        .dma_start   (dma_start),
        .desc_start  (desc_start),
        .push_start  (push_start),
        .ilm_load    (ilm_load),
        .ilm_value   (ilm_value),
        .s_flag_set  (s_flag_set),
        .vec_valid   (vec_valid),
        .vec_addr    (vec_addr)
    );

    irqd_pusher u_push (
        .clk      (clk),
        .rst      (rst),
        .start    (push_start),
        .ctx_in   (ctx_now),
        .sp_in    (sp_in),
        .wr_ready (stk_wr_ready),
        .wr_valid (stk_wr_valid),
        .wr_addr  (stk_wr_addr),
        .wr_data  (stk_wr_data),
        .done     (push_done)
    );

    // R1: a hardware acceptance has all three enable flags set
    a_r1_flags: assert property (@(posedge clk) disable iff (rst)
        acc_pulse && !acc_swi |-> cpu_ie && src_req[acc_src] && src_en[acc_src]);

    // R2: a hardware acceptance has a level strictly below the mask
    a_r2_level: assert property (@(posedge clk) disable iff (rst)
        acc_pulse && !acc_swi |-> (src_lvl[int'(acc_src)*LVL_W +: LVL_W] < cpu_ilm));

    // R4: acceptance only on a boundary while idle, and service follows
    a_r4_boundary: assert property (@(posedge clk) disable iff (rst)
        acc_pulse |-> at_boundary && !busy);
    a_r4_busy_after: assert property (@(posedge clk) disable iff (rst)
        acc_pulse |=> busy);

endmodule

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;

    localparam int          NSRC  = 4;
    localparam int          LVL_W = 3;
    localparam int          VEC_W = 8;
    localparam logic [23:0] TBASE = 24'h00FFFC;
    localparam int K_ACC = 0, K_DMA = 1, K_DESC = 2, K_STK = 3, K_VEC = 4;

    logic clk = 1'b0, rst = 1'b1;
    always #5 clk = ~clk;

    logic              cpu_ie = 0, at_boundary = 0, swi_req = 0;
    logic [LVL_W-1:0]  cpu_ilm = '0;
    logic [NSRC-1:0]   src_req = '0, src_en = '0, src_dma_en = '0, src_desc_en = '0;
    logic [NSRC*LVL_W-1:0] src_lvl = '0;
    logic [VEC_W-1:0]  swi_num = '0;
    logic [15:0] ctx_a = 16'hA001, ctx_dpr = 16'h0D02, ctx_dtb = 16'h0B03;
    logic [15:0] ctx_pcb = 16'h0C04, ctx_pc = 16'h1234, ctx_ps = 16'h5A06;
    logic [23:0] sp_in = 24'h000800;
    logic dma_done = 0, desc_done = 0, stk_wr_ready = 0;

    logic        acc_pulse, acc_swi, busy, dma_start, desc_start;
    logic [1:0]  acc_src;
    logic        stk_wr_valid, ilm_load, s_flag_set, vec_valid;
    logic [23:0] stk_wr_addr, vec_addr;
    logic [15:0] stk_wr_data;
    logic [LVL_W-1:0] ilm_value;

    irq_dispatch #(.NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(TBASE)) u0 (
        .clk(clk), .rst(rst), .cpu_ie(cpu_ie), .cpu_ilm(cpu_ilm),
        .at_boundary(at_boundary), .src_req(src_req), .src_en(src_en),
        .src_lvl(src_lvl), .src_dma_en(src_dma_en), .src_desc_en(src_desc_en),
        .swi_req(swi_req), .swi_num(swi_num), .ctx_a(ctx_a), .ctx_dpr(ctx_dpr),
        .ctx_dtb(ctx_dtb), .ctx_pcb(ctx_pcb), .ctx_pc(ctx_pc), .ctx_ps(ctx_ps),
        .sp_in(sp_in), .dma_done(dma_done), .desc_done(desc_done),
        .stk_wr_ready(stk_wr_ready), .acc_pulse(acc_pulse), .acc_swi(acc_swi),
        .acc_src(acc_src), .busy(busy), .dma_start(dma_start),
        .desc_start(desc_start), .stk_wr_valid(stk_wr_valid),
        .stk_wr_addr(stk_wr_addr), .stk_wr_data(stk_wr_data),
        .ilm_load(ilm_load), .ilm_value(ilm_value), .s_flag_set(s_flag_set),
        .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] d;
    } item_t;

    item_t exp_q[$];
    int checks = 0, errors = 0, acc_seen = 0;
    bit finished = 0;

    function automatic string tag_of(input int k);
        case (k)
            K_ACC:  return "R3";
            K_DMA:  return "R5";
            K_DESC: return "R6";
            K_STK:  return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each produced event with the head of the queue
    task automatic observe(input int k, input logic [31:0] a, input logic [31:0] d);
        item_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, tag_of(k), $sformatf("unexpected event kind %0d", k), d, 32'hFFFFFFFF);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k && e.a == a && e.d == d, tag_of(e.kind),
                  $sformatf("event kind %0d/%0d addr %h/%h", k, e.kind, a, e.a), d, e.d);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (acc_pulse) begin
                acc_seen++;
                observe(K_ACC, 32'h0, 32'({acc_swi, acc_src}));
            end
            if (dma_start)  observe(K_DMA, 32'h0, 32'(acc_src));
            if (desc_start) observe(K_DESC, 32'h0, 32'(acc_src));
            if (stk_wr_valid && stk_wr_ready) observe(K_STK, 32'(stk_wr_addr), 32'(stk_wr_data));
            if (vec_valid)
                observe(K_VEC, 32'(vec_addr),
                        32'({s_flag_set, ilm_load, (ilm_load ? ilm_value : 3'd0)}));
        end
    end

    // Stack ready pattern with periodic stalls
    int rcnt = 0;
    always @(posedge clk) begin
        #1;
        rcnt++;
        stk_wr_ready = (rcnt % 3) != 1;
    end

    // Driver helpers: push expectations derived from the requirements
    task automatic exp_ev(input int k, input logic [31:0] a, input logic [31:0] d);
        item_t e;
        e.kind = k; e.a = a; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic exp_acc(input bit swi, input int src);
        exp_ev(K_ACC, 32'h0, 32'((swi ? 4 : 0) + src));
    endtask

    task automatic exp_vectored(input int num, input bit hw, input int lvl);
        logic [15:0] w[6];
        w[0] = ctx_a; w[1] = ctx_dpr; w[2] = ctx_dtb;
        w[3] = ctx_pcb; w[4] = ctx_pc; w[5] = ctx_ps;
        for (int i = 0; i < 6; i++)
            exp_ev(K_STK, 32'(sp_in - 24'(i + 1)), 32'(w[i]));
        exp_ev(K_VEC, 32'(TBASE - 24'(4 * num)), 32'(16 + (hw ? 8 + lvl : 0)));
    endtask

    task automatic set_lvl(input int s, input int l);
        src_lvl[s*LVL_W +: LVL_W] = LVL_W'(l);
    endtask

    task automatic pulse_boundary();
        @(posedge clk); #1 at_boundary = 1;
        @(posedge clk); #1 at_boundary = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        check(!busy, req, "busy after service", 32'(busy), 32'h0);
        check(exp_q.size() == 0, req, "expected events left", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R10: reset state
        check(!acc_pulse && !busy && !dma_start && !desc_start && !stk_wr_valid
              && !vec_valid && !ilm_load, "R10", "outputs after reset",
              32'({acc_pulse, busy, dma_start, desc_start, stk_wr_valid, vec_valid, ilm_load}), 32'h0);

        // R1: flags gate eligibility
        @(posedge clk); #1;
        cpu_ilm = 3'd7; set_lvl(0, 2); src_req = 4'b0001; src_en = 4'b0001; cpu_ie = 0;
        base = acc_seen;
        pulse_boundary();
        #1 cpu_ie = 1; src_en = 4'b0000;
        pulse_boundary();
        #1 src_en = 4'b0001; src_req = 4'b0000;
        pulse_boundary();
        repeat (2) @(negedge clk);
        check(acc_seen == base, "R1", "acceptances with a flag clear", 32'(acc_seen - base), 32'h0);

        // R2: equal level refused, lower level taken
        #1 cpu_ilm = 3'd3; set_lvl(2, 3); src_req = 4'b0100; src_en = 4'b0100;
        base = acc_seen;
        pulse_boundary();
        repeat (2) @(negedge clk);
        check(acc_seen == base, "R2", "acceptance with level equal to mask", 32'(acc_seen - base), 32'h0);
        #1 set_lvl(2, 2);
        exp_acc(0, 2); exp_vectored(2, 1, 2);
        pulse_boundary();
        #1 src_req = '0;
        wait_idle("R2");

        // R3: tie at same level goes to lower index
        #1 cpu_ilm = 3'd7; src_en = 4'b1111;
        set_lvl(1, 4); set_lvl(3, 4); src_req = 4'b1010;
        exp_acc(0, 1); exp_vectored(1, 1, 4);
        pulse_boundary();
        #1 src_req = '0;
        wait_idle("R3");
        // R3: smaller level beats lower index
        #1 set_lvl(0, 5); set_lvl(2, 1); src_req = 4'b0101;
        ctx_pc = 16'h2468; sp_in = 24'h000700;
        exp_acc(0, 2); exp_vectored(2, 1, 1);
        pulse_boundary();
        #1 src_req = '0;
        wait_idle("R3");

        // R4: no acceptance off-boundary, none while busy
        #1 set_lvl(0, 1); src_req = 4'b0001;
        base = acc_seen;
        repeat (5) @(negedge clk);
        check(acc_seen == base, "R4", "acceptance without boundary", 32'(acc_seen - base), 32'h0);
        exp_acc(0, 0); exp_vectored(0, 1, 1);
        pulse_boundary();
        #1 src_req = 4'b1000; set_lvl(3, 0);
        pulse_boundary();
        check(busy, "R4", "still busy during second boundary", 32'(busy), 32'h1);
        wait_idle("R4");
        check(acc_seen == base + 1, "R4", "acceptances while busy", 32'(acc_seen - base), 32'h1);
        exp_acc(0, 3); exp_vectored(3, 1, 0);
        pulse_boundary();
        #1 src_req = '0;
        wait_idle("R4");

        // R5: DMA path, then vectored entry after completion
        #1 set_lvl(1, 3); src_dma_en = 4'b0010; src_req = 4'b0010;
        exp_acc(0, 1); exp_ev(K_DMA, 32'h0, 32'd1);
        pulse_boundary();
        #1 src_req = '0;
        repeat (6) @(negedge clk);
        check(busy && exp_q.size() == 0, "R5", "waiting for DMA with no stack write",
              32'(exp_q.size()), 32'h0);
        #1 ctx_a = 16'hA0F0;
        exp_vectored(1, 1, 3);
        @(posedge clk); #1 dma_done = 1;
        @(posedge clk); #1 dma_done = 0;
        wait_idle("R5");

        // R6: descriptor path, no context push
        #1 src_dma_en = '0; src_desc_en = 4'b0100; set_lvl(2, 2); src_req = 4'b0100;
        exp_acc(0, 2); exp_ev(K_DESC, 32'h0, 32'd2);
        pulse_boundary();
        #1 src_req = '0;
        repeat (5) @(negedge clk);
        check(busy, "R6", "busy during descriptor service", 32'(busy), 32'h1);
        @(posedge clk); #1 desc_done = 1;
        @(posedge clk); #1 desc_done = 0;
        wait_idle("R6");
        // R5: DMA flag wins when both service flags are set
        #1 src_dma_en = 4'b0001; src_desc_en = 4'b0001; set_lvl(0, 6); src_req = 4'b0001;
        exp_acc(0, 0); exp_ev(K_DMA, 32'h0, 32'd0);
        pulse_boundary();
        #1 src_req = '0;
        exp_vectored(0, 1, 6);
        repeat (3) @(posedge clk);
        #1 dma_done = 1;
        @(posedge clk); #1 dma_done = 0;
        wait_idle("R5");

        // R9: software INT ignores enable and mask
        #1 src_dma_en = '0; src_desc_en = '0; cpu_ie = 0; cpu_ilm = 3'd0;
        swi_req = 1; swi_num = 8'h10;
        exp_acc(1, 0); exp_vectored(16, 0, 0);
        pulse_boundary();
        #1 swi_req = 0;
        wait_idle("R9");
        // R9: hardware taken first when both present
        #1 cpu_ie = 1; cpu_ilm = 3'd7; set_lvl(1, 2); src_req = 4'b0010; swi_req = 1;
        exp_acc(0, 1); exp_vectored(1, 1, 2);
        pulse_boundary();
        #1 swi_req = 0; src_req = '0;
        wait_idle("R9");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule